// File: doc/BRIEF.md
# Processor Mode and Register Width Controller

This block keeps the status flags of an 8/16-bit processor that starts up compatible with a classic 8-bit core. Alongside the visible status byte it owns a hidden emulation bit, a 16-bit accumulator whose upper half stays alive as a hidden byte while the accumulator is narrow, and two index registers that always share one width. The surrounding core issues one-cycle strobes. These can exchange carry with the emulation bit, clear status bits under a mask, set status bits under a mask, swap the accumulator halves, or load a register from a 16-bit data bus.

The unit applies the width rules at the moment the mode flags change. Narrowing the index width wipes the index high bytes. Narrowing the accumulator keeps its high byte, and widening brings that byte back. Entering emulation forces both widths to 8 bits. Instruction decode, arithmetic and interrupt handling live elsewhere and drive this block through its strobes.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: After reset the emulation bit is 1, the status byte reads 8'h34 (bit 5 = 1, bit 4 = break flag = 1, bit 2 = interrupt mask = 1, all other bits 0), both widths are 8 bits, and the accumulator and index registers are 0.
- R2: An exchange strobe swaps status bit 0 (carry) with the emulation bit in one cycle. Emulation bit 1 means emulation mode and 0 means native mode.
- R3: The emulation bit changes only through the exchange strobe. Mask operations with any operand leave it unchanged.
- R4: In native mode status bit 5 selects the accumulator width and bit 4 the index width. A value of 1 means 8 bits and 0 means 16 bits. acc_wide and idx_wide are the inverses of these bits.
- R5: A clear strobe clears every status bit whose operand bit is 1 and leaves the others unchanged.
- R6: A set strobe sets every status bit whose operand bit is 1 and leaves the others unchanged.
- R7: When the index width becomes 8 bits, the high bytes of both index registers become 0. Returning to 16 bits does not restore them.
- R8: The accumulator high byte survives narrowing and widening of the accumulator. A load while the accumulator is 8 bits writes only the low byte.
- R9: A swap strobe exchanges the accumulator low and high bytes in either width.
- R10: In emulation mode status bit 5 reads 1 and bit 4 reads the break flag, which the mask operations clear and set. Both widths stay at 8 bits whatever the masks do.
- R11: Entering emulation mode forces both widths to 8 bits and clears the index high bytes in the same cycle.
- R12: Register loads use the widths that result from that cycle's operation. An 8-bit index load writes the low byte and zeroes the high byte. A 16-bit load writes all 16 bits.
- R13: When several operation strobes coincide, only one is applied, in the priority order exchange, clear, set, swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_xce | input | 1 | Exchange carry with the emulation bit |
| op_clr | input | 1 | Clear status bits selected by operand |
| op_set | input | 1 | Set status bits selected by operand |
| op_swap | input | 1 | Swap accumulator halves |
| operand | input | 8 | Mask for clear and set operations |
| ld_acc | input | 1 | Load accumulator from ld_data |
| ld_x | input | 1 | Load first index register from ld_data |
| ld_y | input | 1 | Load second index register from ld_data |
| ld_data | input | 16 | Load data |
| status | output | 8 | Visible status byte |
| emu | output | 1 | Emulation bit |
| acc_wide | output | 1 | Accumulator is 16 bits |
| idx_wide | output | 1 | Index registers are 16 bits |
| acc | output | 16 | Accumulator, high byte is the hidden byte when narrow |
| x_reg | output | 16 | First index register |
| y_reg | output | 16 | Second index register |

## Verification
On every cycle the assertions check several properties. They check that emulation mode pins both widths to 8 bits and that a narrow index never exposes a nonzero high byte. They also check that the exchange really swaps carry and mode, that only the exchange moves the emulation bit, and the mask effects on ordinary flags. Some behaviour only the bench scenarios can show. These are a hidden accumulator byte coming back after a narrow-then-wide round trip, an index high byte that stays lost after widening, loads that land in the same cycle as a width change, and the priority between coinciding strobes.

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_xce,
  input  logic        op_clr,
  input  logic        op_set,
  input  logic        op_swap,
  input  logic [7:0]  operand,
  input  logic        ld_acc,
  input  logic        ld_x,
  input  logic        ld_y,
  input  logic [15:0] ld_data,
  output logic [7:0]  status,
  output logic        emu,
  output logic        acc_wide,
  output logic        idx_wide,
  output logic [15:0] acc,
  output logic [15:0] x_reg,
  output logic [15:0] y_reg
);

  localparam logic [7:0] FLAGS_RST = 8'h34;

  logic [7:0]  fl_q, fl_n;
  logic        emu_q, emu_n;
  logic        brk_q, brk_n;
  logic [15:0] acc_q, acc_n, x_q, x_n, y_q, y_n;

  always_comb begin
    fl_n  = fl_q;
    emu_n = emu_q;
    brk_n = brk_q;
    acc_n = acc_q;
    x_n   = x_q;
    y_n   = y_q;

    if (op_xce) begin
      emu_n   = fl_q[0];
      fl_n[0] = emu_q;
    end else if (op_clr) begin
      fl_n = fl_q & ~operand;
      if (emu_q) brk_n = brk_q & ~operand[4];
    end else if (op_set) begin
      fl_n = fl_q | operand;
      if (emu_q) brk_n = brk_q | operand[4];
    end else if (op_swap) begin
      acc_n = {acc_q[7:0], acc_q[15:8]};
    end

    if (emu_n) fl_n[5:4] = 2'b11;

    if (fl_n[4]) begin
      x_n[15:8] = 8'h00;
      y_n[15:8] = 8'h00;
    end

    if (ld_acc) acc_n = fl_n[5] ? {acc_n[15:8], ld_data[7:0]} : ld_data;
    if (ld_x)   x_n   = fl_n[4] ? {8'h00, ld_data[7:0]} : ld_data;
    if (ld_y)   y_n   = fl_n[4] ? {8'h00, ld_data[7:0]} : ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q  <= FLAGS_RST;
      emu_q <= 1'b1;
      brk_q <= 1'b1;
      acc_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      fl_q  <= fl_n;
      emu_q <= emu_n;
      brk_q <= brk_n;
      acc_q <= acc_n;
      x_q   <= x_n;
      y_q   <= y_n;
    end
  end

  assign status   = emu_q ? {fl_q[7:6], 1'b1, brk_q, fl_q[3:0]} : fl_q;
  assign emu      = emu_q;
  assign acc_wide = ~fl_q[5];
  assign idx_wide = ~fl_q[4];
  assign acc      = acc_q;
  assign x_reg    = x_q;
  assign y_reg    = y_q;

endmodule

// File: rtl/cpu_mode_ctrl_chk.sv
module cpu_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_xce,
  input logic        op_clr,
  input logic        op_set,
  input logic        op_swap,
  input logic [7:0]  operand,
  input logic        ld_acc,
  input logic [7:0]  status,
  input logic        emu,
  input logic        acc_wide,
  input logic        idx_wide,
  input logic [15:0] acc,
  input logic [15:0] x_reg,
  input logic [15:0] y_reg
);

  assert_emu_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    emu |-> (status[5] && !acc_wide && !idx_wide));

  assert_idx_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wide |-> (x_reg[15:8] == 8'h00 && y_reg[15:8] == 8'h00));

  assert_width_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !emu |-> (acc_wide == !status[5] && idx_wide == !status[4]));

  assert_xce_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_xce |=> (emu == $past(status[0]) && status[0] == $past(emu)));

  assert_emu_only_xce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_xce |=> $stable(emu));

  assert_clr_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_clr && !op_xce) |=> ((status & $past(operand) & 8'hCF) == 8'h00));

  assert_set_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_set && !op_xce && !op_clr) |=>
      ((status & $past(operand) & 8'hCF) == ($past(operand) & 8'hCF)));

  assert_acc_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_swap && !op_xce && !op_clr && !op_set && !ld_acc) |=>
      (acc == {$past(acc[7:0]), $past(acc[15:8])}));

  assert_acc_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_swap && !ld_acc) |=> $stable(acc));

endmodule

bind cpu_mode_ctrl cpu_mode_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .op_xce(op_xce), .op_clr(op_clr), .op_set(op_set),
  .op_swap(op_swap), .operand(operand), .ld_acc(ld_acc), .status(status),
  .emu(emu), .acc_wide(acc_wide), .idx_wide(idx_wide), .acc(acc),
  .x_reg(x_reg), .y_reg(y_reg)
);

// File: tb/cpu_mode_ctrl_test.sv
module cpu_mode_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_xce = 1'b0, op_clr = 1'b0, op_set = 1'b0, op_swap = 1'b0;
  logic [7:0]  operand = 8'h00;
  logic        ld_acc = 1'b0, ld_x = 1'b0, ld_y = 1'b0;
  logic [15:0] ld_data = 16'h0000;
  logic [7:0]  status;
  logic        emu, acc_wide, idx_wide;
  logic [15:0] acc, x_reg, y_reg;

  always #5 clk = ~clk;

  cpu_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_xce(op_xce), .op_clr(op_clr), .op_set(op_set),
    .op_swap(op_swap), .operand(operand), .ld_acc(ld_acc), .ld_x(ld_x), .ld_y(ld_y),
    .ld_data(ld_data), .status(status), .emu(emu), .acc_wide(acc_wide),
    .idx_wide(idx_wide), .acc(acc), .x_reg(x_reg), .y_reg(y_reg)
  );

  typedef struct {
    string       tag;
    logic [58:0] vec;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  logic        m_emu, m_brk;
  logic [7:0]  m_fl;
  logic [15:0] m_acc, m_x, m_y;

  function automatic logic [58:0] actual_vec();
    return {status, emu, acc_wide, idx_wide, acc, x_reg, y_reg};
  endfunction

  function automatic logic [58:0] model_vec();
    logic [7:0] st;
    st = m_emu ? {m_fl[7:6], 1'b1, m_brk, m_fl[3:0]} : m_fl;
    return {st, m_emu, ~m_fl[5], ~m_fl[4], m_acc, m_x, m_y};
  endfunction

  task automatic check(input string tag, input logic [58:0] act, input logic [58:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit xce, input bit clr, input bit set, input bit swp,
                      input logic [7:0] opd, input bit la, input bit lx, input bit ly,
                      input logic [15:0] d, input string tag);
    exp_t it;
    @(negedge clk);
    op_xce = xce; op_clr = clr; op_set = set; op_swap = swp; operand = opd;
    ld_acc = la; ld_x = lx; ld_y = ly; ld_data = d;
    if (xce) begin
      logic t;
      t = m_emu; m_emu = m_fl[0]; m_fl[0] = t;
    end else if (clr) begin
      if (m_emu) m_brk = m_brk & ~opd[4];
      m_fl = m_fl & ~opd;
    end else if (set) begin
      if (m_emu) m_brk = m_brk | opd[4];
      m_fl = m_fl | opd;
    end else if (swp) begin
      m_acc = {m_acc[7:0], m_acc[15:8]};
    end
    if (m_emu) m_fl[5:4] = 2'b11;
    if (m_fl[4]) begin m_x[15:8] = 8'h00; m_y[15:8] = 8'h00; end
    if (la) m_acc = m_fl[5] ? {m_acc[15:8], d[7:0]} : d;
    if (lx) m_x = m_fl[4] ? {8'h00, d[7:0]} : d;
    if (ly) m_y = m_fl[4] ? {8'h00, d[7:0]} : d;
    it.tag = tag;
    it.vec = model_vec();
    exp_q.push_back(it);
    @(posedge clk);
    #1;
    op_xce = 0; op_clr = 0; op_set = 0; op_swap = 0; ld_acc = 0; ld_x = 0; ld_y = 0;
  endtask

  always begin
    @(posedge clk);
    #2;
    while (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.tag, actual_vec(), it.vec);
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_emu = 1'b1; m_brk = 1'b1; m_fl = 8'h34; m_acc = 0; m_x = 0; m_y = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", actual_vec(), {8'h34, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0});

    step(0,1,0,0,8'h30,0,0,0,16'h0,"R10 emu clear keeps 8-bit, clears break");
    step(0,0,1,0,8'h10,0,0,0,16'h0,"R10 emu set break");
    step(0,0,1,0,8'hFF,0,0,0,16'h0,"R3 R6 set all in emu");
    step(0,1,0,0,8'hFF,0,0,0,16'h0,"R3 R5 clear all in emu");
    step(0,0,1,0,8'h14,0,0,0,16'h0,"R6 restore I and break");
    step(0,0,0,0,8'h00,1,1,1,16'h1234,"R8 R12 narrow loads");
    step(1,0,0,0,8'h00,0,0,0,16'h0,"R2 enter native");
    step(1,0,0,0,8'h00,0,0,0,16'h0,"R2 back to emulation");
    step(1,0,0,0,8'h00,0,0,0,16'h0,"R2 native again");
    step(0,1,0,0,8'h30,0,0,0,16'h0,"R4 widen both");
    step(0,0,0,0,8'h00,1,1,0,16'hABCD,"R12 wide loads");
    step(0,0,0,0,8'h00,0,0,1,16'h5566,"R12 wide y load");
    step(0,0,0,1,8'h00,0,0,0,16'h0,"R9 swap wide");
    step(0,0,1,0,8'h20,0,0,0,16'h0,"R4 R8 narrow acc keeps high");
    step(0,0,0,1,8'h00,0,0,0,16'h0,"R9 swap narrow");
    step(0,0,0,0,8'h00,1,0,0,16'h00EE,"R8 narrow acc load low only");
    step(0,1,0,0,8'h20,0,0,0,16'h0,"R8 widen acc restores high");
    step(0,0,1,0,8'h10,0,0,0,16'h0,"R7 narrow index zeroes highs");
    step(0,1,0,0,8'h10,0,0,0,16'h0,"R7 widen does not restore");
    step(0,0,0,0,8'h00,0,1,0,16'hBEEF,"R12 wide x load");
    step(0,0,1,0,8'h10,0,1,1,16'h7777,"R12 load with narrowing in same cycle");
    step(0,1,1,0,8'hC0,0,0,0,16'h0,"R13 clear beats set");
    step(0,1,0,1,8'h10,0,0,0,16'h0,"R13 clear beats swap");
    step(0,0,0,0,8'h00,0,1,1,16'hCAFE,"R12 wide index reload");
    step(0,0,1,0,8'h01,0,0,0,16'h0,"R6 set carry");
    step(1,1,0,0,8'h01,0,0,0,16'h0,"R11 R13 enter emulation clears highs");
    step(0,1,0,0,8'h30,0,0,0,16'h0,"R10 stays narrow in emulation");
    step(0,0,0,0,8'h00,1,1,0,16'h9999,"R8 R12 emu loads narrow");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule